// File: doc/BRIEF.md
# Flash autoselect ID probe

This block reads the manufacturer and device identifiers from a parallel NOR flash that answers the common unlock-and-command protocol. A single `start` pulse launches a fixed sequence of eleven bus accesses at the given base address. The sequence puts the device back in read mode, enters identifier mode, reads the two ID words, and then leaves identifier mode with another reset. Each access takes one clock. Every command is preceded by the two-write unlock pair.

The probe does not know ahead of time whether the data bus carries one device or two x16 devices side by side. It therefore writes every command duplicated into both 16-bit halves of the data word. On a 32-bit bus it decides the arrangement from the replies: if both ID words carry identical halves, it reports two interleaved devices and folds each ID down to 16 bits. The IDs are only reported. Matching them against a part list is left to the caller.

Top module: `nor_id_probe`

## Requirements
- R1: After reset, `busy`, `done`, `bus_we` and `bus_re` are 0, and `mfr_id`, `dev_id` and `dual_dev` are 0.
- R2: Every command is a three-write group: data low byte 0xAA at word 0x555, then 0x55 at word 0x2AA, then the command byte at word 0x555.
- R3: Starting from the clock after `start` is taken, the bus performs eleven accesses, one per clock and never a read and a write together. The order is: reset group (0xF0), identifier-mode group (0x90), read word 0, read word 1, reset group (0xF0).
- R4: Every write puts the same value in both 16-bit halves of `bus_wdata`, shaped as `{8'h00, cmd, 8'h00, cmd}`.
- R5: The byte address is `base_addr` plus the word address shifted left by the bus width code: code 0 (8-bit) shifts by 0, code 1 (16-bit) by 1, and codes 2 and 3 (32-bit) by 2.
- R6: On an 8-bit or 16-bit bus, the read data is masked to the low 8 or 16 bits, and `dual_dev` is 0.
- R7: On a 32-bit bus, if both ID words have equal upper and lower halves, `dual_dev` is 1 and each ID is reduced to its low 16 bits. Otherwise `dual_dev` is 0 and the full words are reported.
- R8: `done` is high for exactly one clock, in the clock after the final reset write. `busy` is high from the clock after `start` through that final write.
- R9: A `start` that arrives while `busy` is high is ignored. The running probe keeps its base address and length, and `done` still pulses once.
- R10: `mfr_id`, `dev_id` and `dual_dev` are valid when `done` is high and hold their values until the next probe completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a probe (taken only when idle) |
| base_addr | input | AW | Byte address of the device |
| bus_width | input | 2 | 0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit data bus |
| bus_addr | output | AW | Byte address of the current access |
| bus_wdata | output | 32 | Write data |
| bus_we | output | 1 | Write strobe, one access per clock |
| bus_re | output | 1 | Read strobe; data sampled at the end of the same clock |
| bus_rdata | input | 32 | Read data from the flash |
| mfr_id | output | 32 | Manufacturer identifier |
| dev_id | output | 32 | Device identifier |
| dual_dev | output | 1 | Two interleaved x16 devices detected |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
A step counter that is off by one shows at the ports in the very next access: the wrong address or command appears on the bus. A flash model that tracks identifier mode then returns erased data instead of the IDs, so the reported IDs go wrong within the same probe. A skipped exit reset leaves the model in identifier mode when `done` rises, and the bench catches it at that edge. A wrong fold decision or a wrong read mask shows only in `mfr_id`, `dev_id` and `dual_dev` at the `done` pulse. The bench therefore uses ID pairs whose halves differ in one word only, and pairs that carry junk in the upper bits.

// File: rtl/nor_id_probe.sv
module nor_id_probe #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [1:0]    bus_width,
  output logic [AW-1:0] bus_addr,
  output logic [31:0]   bus_wdata,
  output logic          bus_we,
  output logic          bus_re,
  input  logic [31:0]   bus_rdata,
  output logic [31:0]   mfr_id,
  output logic [31:0]   dev_id,
  output logic          dual_dev,
  output logic          busy,
  output logic          done
);
  localparam logic [3:0] LAST = 4'd10;
  localparam logic [3:0] RD_MFR = 4'd6;
  localparam logic [3:0] RD_DEV = 4'd7;

  logic [3:0]    step;
  logic [AW-1:0] base_q;
  logic [1:0]    wid_q;
  logic [31:0]   mraw;
  logic [11:0]   wa;
  logic [7:0]    cmd;
  logic          rd;
  logic [1:0]    sh;
  logic [31:0]   rmask, rdm;
  logic          fold;

  always_comb begin
    rd  = 1'b0;
    wa  = 12'h555;
    cmd = 8'hAA;
    case (step)
      4'd1, 4'd4, 4'd9: begin wa = 12'h2AA; cmd = 8'h55; end
      4'd2, 4'd10:      cmd = 8'hF0;
      4'd5:             cmd = 8'h90;
      RD_MFR:           begin rd = 1'b1; wa = 12'h000; end
      RD_DEV:           begin rd = 1'b1; wa = 12'h001; end
      default:          ;
    endcase
  end

  assign sh        = (wid_q == 2'd0) ? 2'd0 : (wid_q == 2'd1) ? 2'd1 : 2'd2;
  assign rmask     = (wid_q == 2'd0) ? 32'h0000_00FF :
                     (wid_q == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign rdm       = bus_rdata & rmask;
  assign bus_addr  = base_q + (AW'(wa) << sh);
  assign bus_wdata = {8'h00, cmd, 8'h00, cmd};
  assign bus_we    = busy & ~rd;
  assign bus_re    = busy & rd;
  assign fold      = wid_q[1] && (mraw[31:16] == mraw[15:0]) && (rdm[31:16] == rdm[15:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      step     <= '0;
      base_q   <= '0;
      wid_q    <= '0;
      mraw     <= '0;
      mfr_id   <= '0;
      dev_id   <= '0;
      dual_dev <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          step   <= '0;
          base_q <= base_addr;
          wid_q  <= bus_width;
        end
      end else begin
        step <= step + 4'd1;
        if (step == RD_MFR) mraw <= rdm;
        if (step == RD_DEV) begin
          dual_dev <= fold;
          mfr_id   <= fold ? {16'h0, mraw[15:0]} : mraw;
          dev_id   <= fold ? {16'h0, rdm[15:0]}  : rdm;
        end
        if (step == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

module nor_id_probe_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        bus_we,
  input logic        bus_re,
  input logic [31:0] bus_wdata
);
  // R3
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n) !(bus_we && bus_re));
  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !(bus_we || bus_re));
  // R4
  dup_halves_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_we |-> bus_wdata[31:16] == bus_wdata[15:0]);
  // R2
  cmd_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> (bus_wdata[7:0] == 8'hAA || bus_wdata[7:0] == 8'h55 ||
                bus_wdata[7:0] == 8'hF0 || bus_wdata[7:0] == 8'h90));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(busy));
  // R9
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
endmodule

bind nor_id_probe nor_id_probe_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata)
);

// File: tb/test_nor_id_probe.sv
module test_nor_id_probe;
  localparam int AW = 24;

  typedef struct packed {
    logic [1:0]    wid;
    logic [AW-1:0] base;
    logic [31:0]   mresp;
    logic [31:0]   dresp;
    logic [31:0]   emfr;
    logic [31:0]   edev;
    logic          eil;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 24'h000000, 32'h0001_0001, 32'h22C4_22C4, 32'h0000_0001, 32'h0000_22C4, 1'b1},
    '{2'd2, 24'h200000, 32'h0001_0001, 32'h22C4_0049, 32'h0001_0001, 32'h22C4_0049, 1'b0},
    '{2'd1, 24'h100000, 32'hABCD_0004, 32'h1234_2249, 32'h0000_0004, 32'h0000_2249, 1'b0},
    '{2'd0, 24'h000800, 32'hFFFF_FF20, 32'h0000_00D7, 32'h0000_0020, 32'h0000_00D7, 1'b0},
    '{2'd3, 24'h3F0000, 32'h0098_0098, 32'h00C2_00C2, 32'h0000_0098, 32'h0000_00C2, 1'b1},
    '{2'd2, 24'h010000, 32'h0020_0020, 32'h0020_0021, 32'h0020_0020, 32'h0020_0021, 1'b0}
  };

  logic          clk = 0;
  logic          rst_n = 0;
  logic          start = 0;
  logic [AW-1:0] base_addr = '0;
  logic [1:0]    bus_width = '0;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata, mfr_id, dev_id;
  logic          bus_we, bus_re, dual_dev, busy, done;

  always #5 clk = ~clk;

  nor_id_probe #(.AW(AW)) i_nor_id_probe (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .bus_width(bus_width),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .mfr_id(mfr_id), .dev_id(dev_id), .dual_dev(dual_dev),
    .busy(busy), .done(done)
  );

  int total = 0, bad = 0;

  // flash model
  logic [AW-1:0] m_base = '0;
  int            m_sc = 1;
  logic [31:0]   m_mresp = '0, m_dresp = '0;
  logic          autosel = 0;
  logic [AW-1:0] h_a [2];
  logic [7:0]    h_d [2];
  logic          lg_we [32];
  logic [AW-1:0] lg_a [32];
  logic [31:0]   lg_d [32];
  int            lg_n = 0;
  int            dup_err = 0;

  assign bus_rdata = !autosel ? 32'hFFFF_FFFF :
                     (bus_addr == m_base) ? m_mresp :
                     (bus_addr == m_base + AW'(m_sc)) ? m_dresp : 32'h0;

  always @(posedge clk) begin
    if (bus_we || bus_re) begin
      if (lg_n < 32) begin
        lg_we[lg_n] = bus_we; lg_a[lg_n] = bus_addr; lg_d[lg_n] = bus_wdata;
      end
      lg_n = lg_n + 1;
    end
    if (bus_we) begin
      if (bus_wdata[31:16] != bus_wdata[15:0]) dup_err = dup_err + 1;
      if (h_a[1] == m_base + AW'(12'h555 * m_sc) && h_d[1] == 8'hAA &&
          h_a[0] == m_base + AW'(12'h2AA * m_sc) && h_d[0] == 8'h55 &&
          bus_addr == m_base + AW'(12'h555 * m_sc)) begin
        if (bus_wdata[7:0] == 8'h90) autosel = 1;
        if (bus_wdata[7:0] == 8'hF0) autosel = 0;
      end
      h_a[1] = h_a[0]; h_d[1] = h_d[0];
      h_a[0] = bus_addr; h_d[0] = bus_wdata[7:0];
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_wa(input int k);
    case (k)
      1, 4, 9: return 12'h2AA;
      6: return 12'h000;
      7: return 12'h001;
      default: return 12'h555;
    endcase
  endfunction

  function automatic logic [7:0] exp_cmd(input int k);
    case (k)
      1, 4, 9: return 8'h55;
      2, 10: return 8'hF0;
      5: return 8'h90;
      default: return 8'hAA;
    endcase
  endfunction

  int done_cnt;
  logic [AW-1:0] bad_a;

  // R2 R3 R5: sequence check against the expected bus trace
  task automatic check_trace(input logic [AW-1:0] b, input int sc, input string tag);
    int errs = 0;
    bad_a = '0;
    for (int k = 0; k < 11; k++) begin
      logic [AW-1:0] ea;
      ea = b + AW'(exp_wa(k) * sc);
      if (k >= lg_n || lg_a[k] != ea || lg_we[k] != (k != 6 && k != 7) ||
          (lg_we[k] && lg_d[k][7:0] != exp_cmd(k))) begin
        if (errs == 0) bad_a = (k < lg_n) ? lg_a[k] : '1;
        errs++;
      end
    end
    check(errs == 0, {tag, " R2/R5 trace"}, 64'(bad_a), 64'(errs));
    check(lg_n == 11, {tag, " R3 access count"}, 64'(lg_n), 64'd11);
  endtask

  task automatic run(input logic [1:0] w, input logic [AW-1:0] b, input logic [31:0] mr,
                     input logic [31:0] dr, input bit restart);
    @(negedge clk);
    m_base = b; m_sc = (w == 0) ? 1 : (w == 1) ? 2 : 4;
    m_mresp = mr; m_dresp = dr;
    lg_n = 0; dup_err = 0; done_cnt = 0;
    bus_width = w; base_addr = b; start = 1;
    @(negedge clk);
    start = 0;
    for (int c = 0; c < 20; c++) begin
      if (restart && c == 3) begin
        base_addr = b + 24'h000100; start = 1;
      end else start = 0;
      if (done) begin
        done_cnt++;
        // R3: exit reset must have left identifier mode
        check(autosel == 0, "R3 exit reset", 64'(autosel), 64'd0);
      end
      @(negedge clk);
    end
    start = 0;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !done && !bus_we && !bus_re, "R1 idle outputs",
          64'({busy, done, bus_we, bus_re}), 64'd0);
    check(mfr_id == 0 && dev_id == 0 && !dual_dev, "R1 ids", 64'(mfr_id), 64'd0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run(VEC[v].wid, VEC[v].base, VEC[v].mresp, VEC[v].dresp, 1'b0);
      check_trace(VEC[v].base, m_sc, $sformatf("vec%0d", v));
      check(dup_err == 0, "R4 duplicated halves", 64'(dup_err), 64'd0);
      check(done_cnt == 1, "R8 done pulses", 64'(done_cnt), 64'd1);
      check(mfr_id == VEC[v].emfr, "R6/R7 mfr_id", 64'(mfr_id), 64'(VEC[v].emfr));
      check(dev_id == VEC[v].edev, "R6/R7 dev_id", 64'(dev_id), 64'(VEC[v].edev));
      check(dual_dev == VEC[v].eil, "R7 dual_dev", 64'(dual_dev), 64'(VEC[v].eil));
    end

    // R10: hold after completion while idle
    repeat (5) @(negedge clk);
    check(mfr_id == VEC[NV-1].emfr && dev_id == VEC[NV-1].edev, "R10 hold",
          64'(mfr_id), 64'(VEC[NV-1].emfr));

    // R8: busy timing relative to start
    @(negedge clk);
    base_addr = 24'h000000; bus_width = 2'd2; m_base = 0; m_sc = 4;
    m_mresp = 32'h00BF_00BF; m_dresp = 32'h2782_2782;
    start = 1;
    @(negedge clk);
    start = 0;
    check(busy == 1, "R8 busy after start", 64'(busy), 64'd1);
    repeat (10) @(negedge clk);
    check(busy == 1 && !done, "R8 busy at last write", 64'({busy, done}), 64'd2);
    @(negedge clk);
    check(!busy && done, "R8 done timing", 64'({busy, done}), 64'd1);
    check(mfr_id == 32'hBF && dev_id == 32'h2782, "R10 valid at done", 64'(dev_id), 64'h2782);
    @(negedge clk);
    check(!done, "R8 done one clock", 64'(done), 64'd0);

    // R9: start while busy ignored
    run(2'd1, 24'h080000, 32'h0000_0001, 32'h0000_225B, 1'b1);
    check_trace(24'h080000, 2, "R9");
    check(done_cnt == 1, "R9 single done", 64'(done_cnt), 64'd1);
    check(mfr_id == 32'h1 && dev_id == 32'h225B, "R9 ids", 64'(dev_id), 64'h225B);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule